// File: doc/BRIEF.md
# Open-Load Diagnostic Sequencer

This controller runs a passive open-load check on the two half-bridge outputs of a motor driver. Once a test starts, the power-stage drive enables are forced off. A pullup current source is then switched on, and each output's pullup comparator is sampled after a settle interval. Next a pulldown source is switched on and each output's pulldown comparator is sampled in the same way. An output counts as open only when both of its comparators read high. Open results are latched in sticky per-output flags and pull an active-low fault line low.

A test request comes from one of two places, chosen by a parameter. In the register variant, software writes a start bit. That bit stays set until the sequence completes and then clears itself. In the pin-configured variant, the test starts automatically at reset release and on every sleep exit, but only when the skip strap is low.

While a test runs, dropping the drive-permit input aborts it with no fault recorded. A request that arrives while the motor is energized waits until the motor is off. The flags are cleared by a clear-fault pulse or by entering sleep.

Top module: `ol_diag_seq`

## Requirements
- R1: While `pu_en` or `pd_en` is high, `drv_en` is 0 for both outputs. While the sequencer is idle, `drv_en` equals `drv_req`.
- R2: The pullup phase (`pu_en` high) lasts exactly SETTLE cycles and is followed immediately by the pulldown phase (`pd_en` high) for SETTLE cycles. `pu_en` and `pd_en` are never high together.
- R3: Bit i of `ol_flag` is set at completion only if `cmp_pu[i]` was high on the last pullup cycle and `cmp_pd[i]` is high on the last pulldown cycle. Comparator values at other times have no effect. Flags accumulate across tests.
- R4: `fault_n` is low exactly when at least one `ol_flag` bit is set.
- R5: `busy` rises two cycles after a `cmd_start` pulse, provided the motor is off and drive is permitted. `done` pulses high for one cycle on the first cycle after the pulldown phase, and `busy` is low in that cycle.
- R6: `start_bit` is set one cycle after `cmd_start`, stays high during the whole test, and is low in the `done` cycle.
- R7: If `drv_allow` is low on a cycle during a test, `busy` is low the next cycle, `start_bit` clears, no `done` pulse occurs, and `ol_flag` keeps its value.
- R8: While `motor_on` is high, a pending start does not begin: `busy` stays low and `start_bit` stays high. The test begins once `motor_on` falls.
- R9: A `clr_flt` pulse while idle clears both `ol_flag` bits on the next cycle.
- R10: `awake` low clears both flags and `start_bit` and returns the sequencer to idle.
- R11: With PIN_MODE=1, a test starts automatically after reset release and on each low-to-high edge of `awake`, provided `strap_skip` is low. With `strap_skip` high, no test runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| awake | input | 1 | High when not in sleep; low clears flags and aborts |
| cmd_start | input | 1 | Register write pulse setting the start bit (register variant) |
| clr_flt | input | 1 | Clear-fault command pulse |
| strap_skip | input | 1 | High skips the automatic test (pin variant) |
| drv_allow | input | 1 | Drive permit; low aborts a running test |
| motor_on | input | 1 | Motor energized status |
| drv_req | input | 2 | Requested drive enables per output |
| cmp_pu | input | 2 | Pullup-phase comparators, high = open |
| cmp_pd | input | 2 | Pulldown-phase comparators, high = open |
| drv_en | output | 2 | Gated drive enables |
| pu_en | output | 1 | Pullup current source enable |
| pd_en | output | 1 | Pulldown current source enable |
| start_bit | output | 1 | Start command bit as read back |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle pulse on normal completion |
| ol_flag | output | 2 | Latched open-load flags |
| fault_n | output | 1 | Active-low fault |

## Verification
The bench targets several corner cases:

- **One phase only open.** An output that reads open in only one phase must not be flagged. A design that ORs the two phases, or that samples the pullup comparator during the pulldown phase, would flag it.
- **Comparator changes between phases.** The comparators are changed at the phase boundary, with junk driven on the inactive comparator. A design that samples at the wrong edge or latches the wrong comparator would be caught.
- **Abort mid-test.** The drive permit is dropped during a test whose comparators all read open. A design that records a fault or pulses `done` on abort would be exposed.
- **Motor energized.** A request is held off while the motor is on. A design that starts the test anyway would be caught.
- **Pin variant.** Both strap values are exercised across reset and sleep exits. A design that ignores the strap or misses the wake edge would be caught.

// File: rtl/ol_diag_seq.sv
module ol_diag_seq #(
  parameter int SETTLE   = 64,
  parameter bit PIN_MODE = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       awake,
  input  logic       cmd_start,
  input  logic       clr_flt,
  input  logic       strap_skip,
  input  logic       drv_allow,
  input  logic       motor_on,
  input  logic [1:0] drv_req,
  input  logic [1:0] cmp_pu,
  input  logic [1:0] cmp_pd,
  output logic [1:0] drv_en,
  output logic       pu_en,
  output logic       pd_en,
  output logic       start_bit,
  output logic       busy,
  output logic       done,
  output logic [1:0] ol_flag,
  output logic       fault_n
);
  localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE - 1);

  typedef enum logic [1:0] {IDLE, PHU, PHD} st_t;
  st_t           state;
  logic [CW-1:0] cnt;
  logic [1:0]    pu_hit, ol_q;
  logic          start_q, awake_q, done_q, start_set;

  assign start_set = PIN_MODE ? (awake & ~awake_q & ~strap_skip) : cmd_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= IDLE;
      cnt     <= '0;
      pu_hit  <= '0;
      ol_q    <= '0;
      start_q <= 1'b0;
      awake_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      awake_q <= awake;
      done_q  <= 1'b0;
      if (!awake) begin
        state   <= IDLE;
        cnt     <= '0;
        start_q <= 1'b0;
        ol_q    <= '0;
      end else begin
        if (clr_flt)   ol_q    <= '0;
        if (start_set) start_q <= 1'b1;
        case (state)
          IDLE: if (start_q && !motor_on && drv_allow) begin
            state <= PHU;
            cnt   <= '0;
          end
          default: begin
            if (!drv_allow) begin
              state   <= IDLE;
              start_q <= 1'b0;
            end else if (cnt == LAST) begin
              cnt <= '0;
              if (state == PHU) begin
                pu_hit <= cmp_pu;
                state  <= PHD;
              end else begin
                ol_q    <= (clr_flt ? 2'b00 : ol_q) | (pu_hit & cmp_pd);
                start_q <= 1'b0;
                done_q  <= 1'b1;
                state   <= IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign busy      = (state != IDLE);
  assign pu_en     = (state == PHU);
  assign pd_en     = (state == PHD);
  assign drv_en    = busy ? 2'b00 : drv_req;
  assign start_bit = start_q;
  assign done      = done_q;
  assign ol_flag   = ol_q;
  assign fault_n   = ~|ol_q;
endmodule

// File: rtl/ol_diag_chk.sv
module ol_diag_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       drv_allow,
  input logic       motor_on,
  input logic       clr_flt,
  input logic       busy,
  input logic       done,
  input logic       start_bit,
  input logic       pu_en,
  input logic       pd_en,
  input logic [1:0] drv_en,
  input logic [1:0] ol_flag
);
  // R1
  drive_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_en || pd_en) |-> drv_en == 2'b00);
  // R2
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pu_en && pd_en));
  // R2
  phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_en) |-> $past(pu_en));
  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R6
  start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> start_bit);
  // R7
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !drv_allow && !clr_flt) |=> (!busy && !done && $stable(ol_flag)));
  // R8
  motor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (motor_on && !busy) |=> !busy);
  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_flt && !busy) |=> ol_flag == 2'b00);
endmodule

bind ol_diag_seq ol_diag_chk u_chk (.*);

// File: tb/sim_ol_diag_seq.sv
module sim_ol_diag_seq;
  localparam int ST = 64;
  localparam int ST1 = 8;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, awake = 1'b1, cmd_start = 1'b0, clr_flt = 1'b0;
  logic drv_allow = 1'b1, motor_on = 1'b0;
  logic [1:0] drv_req = 2'b11, cmp_pu = 2'b00, cmp_pd = 2'b00;
  logic [1:0] drv_en, ol_flag;
  logic pu_en, pd_en, start_bit, busy, done, fault_n;

  logic rst1_n = 1'b0, awake1 = 1'b1, strap1 = 1'b0;
  logic [1:0] drv_en1, ol_flag1;
  logic pu_en1, pd_en1, start1, busy1, done1, fault1_n;

  int checks = 0, errors = 0;
  logic [1:0] exp_fl = 2'b00;

  ol_diag_seq #(.SETTLE(ST), .PIN_MODE(1'b0)) u0 (
    .clk, .rst_n, .awake, .cmd_start, .clr_flt, .strap_skip(1'b0), .drv_allow,
    .motor_on, .drv_req, .cmp_pu, .cmp_pd, .drv_en, .pu_en, .pd_en, .start_bit,
    .busy, .done, .ol_flag, .fault_n);

  ol_diag_seq #(.SETTLE(ST1), .PIN_MODE(1'b1)) u1 (
    .clk, .rst_n(rst1_n), .awake(awake1), .cmd_start(1'b0), .clr_flt(1'b0),
    .strap_skip(strap1), .drv_allow(1'b1), .motor_on(1'b0), .drv_req(2'b11),
    .cmp_pu(2'b01), .cmp_pd(2'b01), .drv_en(drv_en1), .pu_en(pu_en1),
    .pd_en(pd_en1), .start_bit(start1), .busy(busy1), .done(done1),
    .ol_flag(ol_flag1), .fault_n(fault1_n));

  function automatic logic [1:0] ol_next(logic [1:0] old, logic [1:0] a, logic [1:0] b);
    return old | (a & b);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_test(logic [1:0] a, logic [1:0] b);
    int npu, npd;
    cmd_start = 1'b1; tick(); cmd_start = 1'b0;
    chk("R6 start bit set", start_bit, 1); chk("R5 busy low yet", busy, 0);
    tick();
    chk("R5 busy", busy, 1);
    cmp_pu = a; cmp_pd = 2'($urandom);
    npu = 0;
    while (pu_en) begin
      npu++;
      if (drv_en !== 2'b00) chk("R1 drive off", drv_en, 0);
      tick();
    end
    chk("R2 pullup length", npu, ST);
    chk("R2 pulldown follows", pd_en, 1);
    cmp_pd = b; cmp_pu = 2'($urandom);
    npd = 0;
    while (pd_en) begin
      npd++;
      if (!start_bit) chk("R6 start held", start_bit, 1);
      tick();
    end
    chk("R2 pulldown length", npd, ST);
    exp_fl = ol_next(exp_fl, a, b);
    chk("R5 done", done, 1); chk("R5 busy end", busy, 0);
    chk("R6 start cleared", start_bit, 0);
    chk("R3 flags", ol_flag, exp_fl);
    chk("R4 fault_n", fault_n, exp_fl == 2'b00);
    chk("R1 drive restored", drv_en, drv_req);
    tick();
    chk("R5 done one cycle", done, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    tick(2);
    rst_n = 1'b1;
    tick();
    chk("R5 reset busy", busy, 0); chk("R4 reset fault", fault_n, 1);
    chk("R3 reset flags", ol_flag, 0); chk("R1 idle drive", drv_en, 2'b11);

    run_test(2'b01, 2'b10);
    run_test(2'b10, 2'b10);
    run_test(2'b01, 2'b01);

    clr_flt = 1'b1; tick(); clr_flt = 1'b0; exp_fl = 0;
    chk("R9 clear", ol_flag, 0); chk("R4 cleared fault", fault_n, 1);

    for (int k = 0; k < 12; k++) begin
      drv_req = 2'($urandom);
      run_test(2'($urandom), 2'($urandom));
      if ($urandom % 3 == 0) begin
        clr_flt = 1'b1; tick(); clr_flt = 1'b0; exp_fl = 0;
        chk("R9 random clear", ol_flag, 0);
      end
    end

    clr_flt = 1'b1; tick(); clr_flt = 1'b0; exp_fl = 0;
    cmp_pu = 2'b11; cmp_pd = 2'b11;
    cmd_start = 1'b1; tick(); cmd_start = 1'b0;
    tick(10);
    drv_allow = 1'b0; tick(); drv_allow = 1'b1;
    chk("R7 abort busy", busy, 0); chk("R7 abort start", start_bit, 0);
    chk("R7 no done", done, 0);
    tick(2 * ST + 4);
    chk("R7 no fault", ol_flag, 0); chk("R7 fault_n", fault_n, 1);

    motor_on = 1'b1;
    cmd_start = 1'b1; tick(); cmd_start = 1'b0;
    tick(20);
    chk("R8 held busy", busy, 0); chk("R8 pending", start_bit, 1);
    motor_on = 1'b0; tick(2);
    chk("R8 starts", busy, 1);
    tick(2 * ST + 2);
    chk("R8 completes flags", ol_flag, 2'b11);

    awake = 1'b0; tick(); awake = 1'b1;
    chk("R10 sleep clears", ol_flag, 0); chk("R10 fault_n", fault_n, 1);
    cmd_start = 1'b1; tick(); cmd_start = 1'b0; tick(5);
    awake = 1'b0; tick(); awake = 1'b1;
    chk("R10 sleep aborts", busy, 0); chk("R10 start cleared", start_bit, 0);

    strap1 = 1'b0; rst1_n = 1'b1;
    tick(2 * ST1 + 6);
    chk("R11 power-up test", ol_flag1, 2'b01);
    awake1 = 1'b0; tick(); chk("R10 pin sleep clear", ol_flag1, 0);
    strap1 = 1'b1; awake1 = 1'b1;
    begin
      int seen = 0;
      for (int i = 0; i < 2 * ST1 + 6; i++) begin tick(); if (busy1) seen++; end
      chk("R11 strap skips", seen, 0);
    end
    chk("R11 no flags skipped", ol_flag1, 0);
    awake1 = 1'b0; tick(); strap1 = 1'b0; awake1 = 1'b1;
    tick(2 * ST1 + 6);
    chk("R11 wake test", ol_flag1, 2'b01); chk("R11 fault", fault1_n, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule